// File: doc/BRIEF.md
# Control/status register access controller

This block stands between an instruction decoder and a bank of control/status registers. For every request it takes a 12-bit register address, the current privilege level, an operand value and a write mask, plus a flag that marks accesses made by an external debugger. It decides whether the access is legal. If it is, it reads the current register contents, merges in the new value under the mask and writes the result back. It then returns the value the register held before the access.

One interface covers every access form. A plain read uses a zero mask. A swap uses an all-ones mask with the operand as the value. A set uses the operand as the mask with an all-ones value. A clear uses the operand as the mask with a zero value. The register storage sits outside the block behind a combinational read port and a write strobe. For each address the storage also reports an availability class. The controller then applies the gate that belongs to that class: floating-point enable, counter enables, supervisor-mode presence or memory-protection presence.

Top module: `csr_access_unit`

## Requirements
- R1: An access whose current privilege (`req_priv`, 0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8] is illegal.
- R2: An access with a non-zero write mask to an address whose bits [11:10] equal 3 is illegal. A read (zero mask) of such an address is legal if no other rule forbids it.
- R3: A legal access with a non-zero mask drives `rf_we` in the request cycle with `rf_wdata` = (old AND NOT mask) OR (value AND mask). A zero mask never writes.
- R4: One cycle after a request, `rsp_valid` is high and `rsp_rdata` holds the register value from before the access, not the merged value. `rsp_rdata` is zero when the access is illegal.
- R5: Class 2 (floating-point) is illegal when `cfg_fs` is zero, unless `req_dbg` is high.
- R6: Class 3 (counter) is gated by bit index address[4:0]. Below machine privilege that bit of `cfg_menable` must be set. Below supervisor privilege that bit of `cfg_senable` must also be set.
- R7: Class 4 (supervisor) is illegal when `cfg_has_smode` is low. Class 5 (protection) is illegal when `cfg_has_prot` is low.
- R8: Class 0 (no read accessor) and the unused codes 6 and 7 are always illegal. Class 1 is always available.
- R9: `rsp_illegal` is registered one cycle after a request. No register write is issued for an access that is flagged illegal.
- R10: After reset `rsp_valid`, `rsp_illegal` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 12 | Register address |
| req_priv | input | 2 | Current privilege level |
| req_value | input | XLEN | New value operand |
| req_mask | input | XLEN | Write mask |
| req_dbg | input | 1 | Access issued by a debugger |
| cfg_fs | input | 2 | Floating-point state field |
| cfg_menable | input | 32 | Machine-level counter enables |
| cfg_senable | input | 32 | Supervisor-level counter enables |
| cfg_has_smode | input | 1 | Supervisor mode implemented |
| cfg_has_prot | input | 1 | Memory-protection registers implemented |
| rf_addr | output | 12 | Storage read/write address |
| rf_rdata | input | XLEN | Storage read data for `rf_addr` |
| rf_class | input | 3 | Availability class for `rf_addr` |
| rf_we | output | 1 | Storage write strobe |
| rf_wdata | output | XLEN | Storage write data |
| rsp_valid | output | 1 | Response valid |
| rsp_illegal | output | 1 | Access was illegal |
| rsp_rdata | output | XLEN | Register value before the access |

## Verification
The assertions assume three things about the inputs. First, the storage returns `rf_rdata` and `rf_class` combinationally for the address the block presents. Second, `req_priv` never carries the reserved value 2. Third, the configuration inputs hold steady while a request is in flight. The bench models the storage as a small array indexed by address bits [3:0], with the class taken from bits [7:4]. It changes requests and configuration only on the falling edge, one request at a time, and uses only privilege codes 0, 1 and 3.

// File: rtl/csr_access_unit.sv
module csr_access_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_priv,
  input  logic [XLEN-1:0] req_value,
  input  logic [XLEN-1:0] req_mask,
  input  logic            req_dbg,
  input  logic [1:0]      cfg_fs,
  input  logic [31:0]     cfg_menable,
  input  logic [31:0]     cfg_senable,
  input  logic            cfg_has_smode,
  input  logic            cfg_has_prot,
  output logic [11:0]     rf_addr,
  input  logic [XLEN-1:0] rf_rdata,
  input  logic [2:0]      rf_class,
  output logic            rf_we,
  output logic [XLEN-1:0] rf_wdata,
  output logic            rsp_valid,
  output logic            rsp_illegal,
  output logic [XLEN-1:0] rsp_rdata
);
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic priv_low, ro_write, avail, ctr_ok, illegal, has_write;

  assign rf_addr   = req_addr;
  assign has_write = |req_mask;
  assign priv_low  = req_priv < req_addr[9:8];
  assign ro_write  = (req_addr[11:10] == 2'b11) && has_write;

  assign ctr_ok = (req_priv >= PRIV_M || cfg_menable[req_addr[4:0]]) &&
                  (req_priv >= PRIV_S || cfg_senable[req_addr[4:0]]);

  always_comb begin
    case (rf_class)
      3'd1:    avail = 1'b1;
      3'd2:    avail = req_dbg || (cfg_fs != 2'b00);
      3'd3:    avail = ctr_ok;
      3'd4:    avail = cfg_has_smode;
      3'd5:    avail = cfg_has_prot;
      default: avail = 1'b0;
    endcase
  end

  assign illegal  = priv_low || ro_write || !avail;
  assign rf_we    = req_valid && !illegal && has_write;
  assign rf_wdata = (rf_rdata & ~req_mask) | (req_value & req_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && illegal;
      rsp_rdata   <= (req_valid && !illegal) ? rf_rdata : '0;
    end
  end

  // R1
  p_priv_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_priv < req_addr[9:8]) |=> rsp_valid && rsp_illegal);
  // R2
  p_ro_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr[11:10] == 2'b11 && req_mask != '0 |=> rsp_illegal);
  // R3
  p_no_write_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_mask == '0 |-> !rf_we);
  // R4
  p_old_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rf_we && req_mask != '0 |=> rsp_illegal);
  // R4
  p_rdata_zero_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> rsp_rdata == '0);
  // R9
  p_write_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> rsp_valid && !rsp_illegal);
  // R9
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  p_no_accessor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (rf_class == 3'd0 || rf_class > 3'd5) |=> rsp_illegal);
endmodule

// File: tb/csr_access_unit_tb.sv
module csr_access_unit_tb;
  localparam int XLEN = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            req_valid = 1'b0, req_dbg = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [1:0]      req_priv = 2'd3;
  logic [XLEN-1:0] req_value = '0, req_mask = '0;
  logic [1:0]      cfg_fs = 2'd1;
  logic [31:0]     cfg_menable = '1, cfg_senable = '1;
  logic            cfg_has_smode = 1'b1, cfg_has_prot = 1'b1;
  logic [11:0]     rf_addr;
  logic [XLEN-1:0] rf_rdata, rf_wdata, rsp_rdata;
  logic [2:0]      rf_class;
  logic            rf_we, rsp_valid, rsp_illegal;

  logic [XLEN-1:0] mem [16];
  logic [XLEN-1:0] model [16];
  int writes = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  csr_access_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_value(req_value), .req_mask(req_mask),
    .req_dbg(req_dbg), .cfg_fs(cfg_fs), .cfg_menable(cfg_menable),
    .cfg_senable(cfg_senable), .cfg_has_smode(cfg_has_smode),
    .cfg_has_prot(cfg_has_prot), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .rf_class(rf_class), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata));

  // storage model: index addr[3:0], class addr[7:4] (0..4 -> classes 1..5, else 0)
  assign rf_rdata = mem[rf_addr[3:0]];
  assign rf_class = (rf_addr[7:4] <= 4'd4) ? 3'(rf_addr[7:4] + 4'd1) : 3'd0;

  always_ff @(posedge clk) begin
    if (rf_we) begin
      mem[rf_addr[3:0]] <= rf_wdata;
      writes <= writes + 1;
    end
  end

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [11:0] addr, input logic [1:0] priv,
                        input logic [XLEN-1:0] val, input logic [XLEN-1:0] msk,
                        input logic dbg, input logic exp_ill);
    int w0;
    logic [XLEN-1:0] exp_rd;
    int idx;
    idx = int'(addr[3:0]);
    exp_rd = exp_ill ? '0 : model[idx];
    w0 = writes;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_priv = priv;
    req_value = val; req_mask = msk; req_dbg = dbg;
    @(negedge clk);
    req_valid = 1'b0; req_mask = '0; req_dbg = 1'b0;
    if (!exp_ill && msk != '0) model[idx] = (model[idx] & ~msk) | (val & msk);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " illegal"}, 32'(rsp_illegal), 32'(exp_ill));
    check({tag, " rdata"}, rsp_rdata, exp_rd);
    check({tag, " R9 write count"}, 32'(writes - w0), (!exp_ill && msk != '0) ? 32'd1 : 32'd0);
    check({tag, " storage"}, mem[idx], model[idx]);
  endtask

  task automatic t_reset;
    check("R10 rsp_valid", 32'(rsp_valid), 0);
    check("R10 rsp_illegal", 32'(rsp_illegal), 0);
    check("R10 rsp_rdata", rsp_rdata, 0);
  endtask

  task automatic t_merge;
    access("R3 swap", 12'h300, 2'd3, 32'hA5A5_0000, 32'hFFFF_FFFF, 0, 0);
    check("R3 swap value", mem[0], 32'hA5A5_0000);
    access("R3 set", 12'h300, 2'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0);
    check("R3 set value", mem[0], 32'hA5A5_00FF);
    access("R3 clear", 12'h300, 2'd3, 32'h0, 32'hFF00_0000, 0, 0);
    check("R3 clear value", mem[0], 32'h00A5_00FF);
    access("R4 plain read", 12'h300, 2'd3, 32'hDEAD_BEEF, 32'h0, 0, 0);
  endtask

  task automatic t_priv;
    access("R1 super to machine", 12'h301, 2'd1, 32'h1, 32'hFFFF_FFFF, 0, 1);
    access("R1 user to super", 12'h101, 2'd0, 32'h0, 32'h0, 0, 1);
    access("R1 super to super", 12'h101, 2'd1, 32'h77, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_readonly;
    access("R2 ro read", 12'hC02, 2'd0, 32'h0, 32'h0, 0, 0);
    access("R2 ro write", 12'hC02, 2'd3, 32'h5, 32'h1, 0, 1);
  endtask

  task automatic t_float;
    cfg_fs = 2'd0;
    access("R5 fs off", 12'h013, 2'd3, 32'h3, 32'h3, 0, 1);
    access("R5 fs off debug", 12'h013, 2'd3, 32'h3, 32'h3, 1, 0);
    cfg_fs = 2'd3;
    access("R5 fs on", 12'h013, 2'd0, 32'h0, 32'h1, 0, 0);
  endtask

  task automatic t_counter;
    cfg_menable = 32'h0000_0010; cfg_senable = 32'h0;
    access("R6 user no senable", 12'hC24, 2'd0, 0, 0, 0, 1);
    access("R6 super menable", 12'hC24, 2'd1, 0, 0, 0, 0);
    cfg_senable = 32'h0000_0010;
    access("R6 user both", 12'hC24, 2'd0, 0, 0, 0, 0);
    cfg_menable = 32'h0000_0008;
    access("R6 super no menable", 12'hC24, 2'd1, 0, 0, 0, 1);
    cfg_menable = 32'h0; cfg_senable = 32'h0;
    access("R6 machine ungated", 12'hC24, 2'd3, 0, 0, 0, 0);
    cfg_menable = '1; cfg_senable = '1;
  endtask

  task automatic t_features;
    cfg_has_smode = 1'b0;
    access("R7 no smode", 12'h135, 2'd1, 32'h9, 32'hF, 0, 1);
    cfg_has_smode = 1'b1;
    access("R7 smode", 12'h135, 2'd1, 32'h9, 32'hF, 0, 0);
    cfg_has_prot = 1'b0;
    access("R7 no prot", 12'h34A, 2'd3, 32'h1, 32'h1, 0, 1);
    cfg_has_prot = 1'b1;
    access("R7 prot", 12'h34A, 2'd3, 32'h1, 32'h1, 0, 0);
  endtask

  task automatic t_none;
    access("R8 no accessor", 12'h3F6, 2'd3, 32'h1, 32'h0, 0, 1);
    access("R8 no accessor write", 12'h356, 2'd3, 32'h1, 32'h1, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1000_0000 + 32'(i);
      model[i] = 32'h1000_0000 + 32'(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_priv();
    t_readonly();
    t_float();
    t_counter();
    t_features();
    t_none();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule